// File: doc/BRIEF.md
# Abstract Command Instruction Generator

This block sits inside a debug unit and turns a register-access command from the debugger into a few instruction words. A halted hart then fetches those words from the debug memory window. A command may ask for a transfer between a data word and scratch register s0. For a register write, the transfer is a load from the data area into s0. For a register read, it is a store from s0 back into the data area. The command may also ask the hart to run the program buffer afterwards. The generated words sit in a two-word abstract region directly below a sixteen-word program buffer, so execution runs straight into the buffer. The word at the jump-target slot always jumps to the abstract region.

The debugger side has one write/read port. It reaches four data words, the program buffer, the command register and an error-clear strobe. The hart side has a one-cycle registered fetch port, a store port into the data area and a completion strobe. To read a CSR, the debugger issues two commands. The first runs only the buffer, which leaves the value in s0. The second transfers s0 out, with no buffer run.

Top module: `abs_cmd_gen`

## Requirements
- R1: After reset, busy, go and err are 0. All data and program-buffer words are 0. Abstract word 0 holds nop 0x00000013 and abstract word 1 holds ebreak 0x00100073.
- R2: Hart fetch offsets are byte offsets, and hart_rd_data is registered one cycle after hart_rd_addr. Offset 0x300 returns jal x0,+0x38 (0x0380006F). The abstract words are at 0x338 and 0x33C, the program buffer word i is at 0x340+4i, and data word i is at 0x380+4i.
- R3: The command word carries kind[31:24] (0 = register access), size[22:20] (2 = 32-bit, 3 = 64-bit), postexec[18], transfer[17] and write[16]. Bits [15:0] are ignored, and the register used is always s0. A started command with transfer=1 and write=1 puts a load into s0 from 0x380(x0) in abstract word 0: lw 0x38002403 for size 2, or ld 0x38003403 for size 3.
- R4: With transfer=1 and write=0, abstract word 0 holds a store of s0 to 0x380(x0): sw 0x38802023 for size 2, or sd 0x38803023 for size 3.
- R5: With transfer=0, abstract word 0 holds nop 0x00000013, whatever the size field holds.
- R6: Abstract word 1 holds nop when postexec=1, so execution falls into the buffer. It holds ebreak when postexec=0. No ebreak is placed after the program buffer: the word after the last buffer word is data word 0.
- R7: A command is accepted when busy=0 and err=0. One cycle after the write, go is high for exactly one cycle and busy is high. busy drops one cycle after hart_done.
- R8: While busy, a command write or a data/program-buffer write is ignored and sets err to 1 (busy error), unless err is already nonzero.
- R9: A command with kind≠0, or with transfer=1 and a size other than 2 or 3, is not started. It sets err to 2 (not supported), and busy and go stay 0.
- R10: err is sticky. While err≠0, command writes are ignored. A write to debugger address 0x21 clears err to 0 on the next cycle.
- R11: Debugger addresses 0x00..0x03 select the data words, 0x10..0x1F select the program-buffer words, and 0x20 selects the command register. dbg_rdata returns the selected data or buffer word combinationally. A hart store in 0x380..0x38F updates the matching data word on the next cycle.
- R12: Hart fetches from offsets outside the jump-target, abstract, program-buffer and data windows return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_wr | input | 1 | Debugger write strobe |
| dbg_addr | input | 6 | Debugger register select |
| dbg_wdata | input | 32 | Debugger write data |
| dbg_rdata | output | 32 | Selected data/buffer word (combinational) |
| hart_rd_addr | input | 12 | Hart fetch/load byte offset |
| hart_rd_data | output | 32 | Fetched word, one cycle later |
| hart_wr | input | 1 | Hart store strobe |
| hart_wr_addr | input | 12 | Hart store byte offset |
| hart_wr_data | input | 32 | Hart store data |
| hart_done | input | 1 | Hart reports the command finished |
| busy | output | 1 | Command in progress |
| go | output | 1 | One-cycle start pulse to the hart |
| err | output | 2 | 0 none, 1 busy error, 2 not supported |

## Verification
Every registered result appears one clock after the edge that captures the stimulus. A command write shows go, busy and err at the following negative edge. A fetch address shows its word one cycle after it is applied. hart_done clears busy at the next edge. dbg_rdata follows dbg_addr with no delay. The bench drives inputs 2 ns after a rising edge. It keeps a behavioural model that it advances on the same rising edge. It compares every output against this model at each falling edge. Directed checks read back the abstract words, the buffer and the data words through the fetch and debugger ports in those same cycles.

// File: rtl/abs_gen_pkg.sv
package abs_gen_pkg;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_BUSY  = 2'd1,
    ERR_UNSUP = 2'd2
  } abs_err_e;

  // Register-access command layout
  typedef struct packed {
    logic [7:0]  kind;
    logic        rsv0;
    logic [2:0]  size;
    logic        rsv1;
    logic        postexec;
    logic        transfer;
    logic        write;
    logic [15:0] regno;
  } abs_cmd_t;

  localparam logic [31:0] INSN_NOP    = 32'h0000_0013;
  localparam logic [31:0] INSN_EBREAK = 32'h0010_0073;
  localparam logic [4:0]  REG_S0      = 5'd8;
  localparam logic [2:0]  SZ_32       = 3'd2;
  localparam logic [2:0]  SZ_64       = 3'd3;

  // I-type load: rd <= mem[x0 + off]
  function automatic logic [31:0] enc_load(input logic [2:0] f3,
                                           input logic [4:0] rd,
                                           input logic [11:0] off);
    return {off, 5'd0, f3, rd, 7'b0000011};
  endfunction

  // S-type store: mem[x0 + off] <= rs2
  function automatic logic [31:0] enc_store(input logic [2:0] f3,
                                            input logic [4:0] rs2,
                                            input logic [11:0] off);
    return {off[11:5], rs2, 5'd0, f3, off[4:0], 7'b0100011};
  endfunction

  // J-type jump with a byte offset
  function automatic logic [31:0] enc_jal(input logic [4:0] rd,
                                          input logic [20:0] off);
    return {off[20], off[10:1], off[11], off[19:12], rd, 7'b1101111};
  endfunction

  // Byte offset a falls in the n-word window starting at base
  function automatic logic in_window(input int a, input int base, input int n);
    return (a >= base) && (a < base + 4 * n);
  endfunction

  function automatic int word_of(input int a, input int base);
    return (a - base) >> 2;
  endfunction

endpackage

// File: rtl/abs_cmd_decode.sv
module abs_cmd_decode
  import abs_gen_pkg::*;
#(
  parameter int DATA_OFF = 'h380
) (
  input  logic [31:0] cmd_word,
  output logic [31:0] word0,
  output logic [31:0] word1,
  output logic        unsupported
);

  localparam logic [11:0] DATA_IMM = 12'(DATA_OFF);

  abs_cmd_t c;
  logic     size_ok;
  logic     unused_fields;

  assign c             = abs_cmd_t'(cmd_word);
  assign unused_fields = ^{c.regno, c.rsv0, c.rsv1};

  always_comb begin
    size_ok     = (c.size == SZ_32) || (c.size == SZ_64);
    unsupported = (c.kind != 8'd0) || (c.transfer && !size_ok);
    if (!c.transfer)
      word0 = INSN_NOP;
    else if (c.write)
      word0 = enc_load(c.size, REG_S0, DATA_IMM);
    else
      word0 = enc_store(c.size, REG_S0, DATA_IMM);
    word1 = c.postexec ? INSN_NOP : INSN_EBREAK;
  end

endmodule

// File: rtl/abs_ctrl.sv
module abs_ctrl
  import abs_gen_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic        cmd_bad,
  input  logic [31:0] dec_w0,
  input  logic [31:0] dec_w1,
  input  logic        err_clr,
  input  logic        buf_wr,
  input  logic        hart_done,
  output logic        busy,
  output logic        go,
  output abs_err_e    err,
  output logic [31:0] abs_w0,
  output logic [31:0] abs_w1,
  output logic        start_evt,
  output logic        bad_evt,
  output logic        busy_hit_evt
);

  logic err_free;

  assign err_free     = (err == ERR_NONE);
  assign start_evt    = cmd_wr && err_free && !busy && !cmd_bad;
  assign bad_evt      = cmd_wr && err_free && !busy && cmd_bad;
  assign busy_hit_evt = (cmd_wr || buf_wr) && err_free && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      go     <= 1'b0;
      err    <= ERR_NONE;
      abs_w0 <= INSN_NOP;
      abs_w1 <= INSN_EBREAK;
    end else begin
      go <= start_evt;
      if (start_evt) begin
        busy   <= 1'b1;
        abs_w0 <= dec_w0;
        abs_w1 <= dec_w1;
      end else if (hart_done) begin
        busy <= 1'b0;
      end
      if (err_clr)
        err <= ERR_NONE;
      else if (bad_evt)
        err <= ERR_UNSUP;
      else if (busy_hit_evt)
        err <= ERR_BUSY;
    end
  end

endmodule

// File: rtl/abs_store.sv
module abs_store #(
  parameter int N_DATA    = 4,
  parameter int N_PROGBUF = 16,
  parameter int IDX_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       allow,
  input  logic                       dbg_data_we,
  input  logic                       dbg_pb_we,
  input  logic [IDX_W-1:0]           dbg_idx,
  input  logic [31:0]                dbg_wdata,
  input  logic                       hart_we,
  input  logic [$clog2(N_DATA)-1:0]  hart_idx,
  input  logic [31:0]                hart_wdata,
  output logic [31:0]                data_q [N_DATA],
  output logic [31:0]                pb_q   [N_PROGBUF]
);

  localparam int DI_W = $clog2(N_DATA);
  localparam int PI_W = $clog2(N_PROGBUF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_DATA; i++)    data_q[i] <= '0;
      for (int j = 0; j < N_PROGBUF; j++) pb_q[j]   <= '0;
    end else begin
      if (hart_we)
        data_q[hart_idx] <= hart_wdata;
      // debugger write lands last, so it wins a same-word collision
      if (dbg_data_we && allow)
        data_q[dbg_idx[DI_W-1:0]] <= dbg_wdata;
      if (dbg_pb_we && allow)
        pb_q[dbg_idx[PI_W-1:0]] <= dbg_wdata;
    end
  end

endmodule

// File: rtl/abs_fetch.sv
module abs_fetch
  import abs_gen_pkg::*;
#(
  parameter int N_DATA      = 4,
  parameter int N_PROGBUF   = 16,
  parameter int N_ABS       = 2,
  parameter int ADDR_W      = 12,
  parameter int DATA_OFF    = 'h380,
  parameter int WHERETO_OFF = 'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [31:0]       abs_w0,
  input  logic [31:0]       abs_w1,
  input  logic [31:0]       data_q [N_DATA],
  input  logic [31:0]       pb_q   [N_PROGBUF],
  output logic [31:0]       rd_data
);

  localparam int PB_OFF  = DATA_OFF - 4 * N_PROGBUF;
  localparam int ABS_OFF = PB_OFF - 4 * N_ABS;
  localparam int DI_W    = $clog2(N_DATA);
  localparam int PI_W    = $clog2(N_PROGBUF);
  localparam logic [31:0] JUMP_WORD = enc_jal(5'd0, 21'(ABS_OFF - WHERETO_OFF));

  int          a;
  logic [31:0] sel;

  always_comb begin
    a   = int'(rd_addr);
    sel = '0;
    if (in_window(a, WHERETO_OFF, 1))
      sel = JUMP_WORD;
    else if (in_window(a, ABS_OFF, 1))
      sel = abs_w0;
    else if (in_window(a, ABS_OFF + 4, 1))
      sel = abs_w1;
    else if (in_window(a, PB_OFF, N_PROGBUF))
      sel = pb_q[PI_W'(word_of(a, PB_OFF))];
    else if (in_window(a, DATA_OFF, N_DATA))
      sel = data_q[DI_W'(word_of(a, DATA_OFF))];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= sel;
  end

endmodule

// File: rtl/abs_cmd_gen.sv
module abs_cmd_gen
  import abs_gen_pkg::*;
#(
  parameter int N_PROGBUF   = 16,
  parameter int N_DATA      = 4,
  parameter int ADDR_W      = 12,
  parameter int DATA_OFF    = 'h380,
  parameter int WHERETO_OFF = 'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_wr,
  input  logic [5:0]        dbg_addr,
  input  logic [31:0]       dbg_wdata,
  output logic [31:0]       dbg_rdata,
  input  logic [ADDR_W-1:0] hart_rd_addr,
  output logic [31:0]       hart_rd_data,
  input  logic              hart_wr,
  input  logic [ADDR_W-1:0] hart_wr_addr,
  input  logic [31:0]       hart_wr_data,
  input  logic              hart_done,
  output logic              busy,
  output logic              go,
  output logic [1:0]        err
);

  localparam int N_ABS = 2;
  localparam int IDX_W = 4;
  localparam int DI_W  = $clog2(N_DATA);
  localparam int PI_W  = $clog2(N_PROGBUF);
  localparam logic [5:0] SEL_CMD = 6'h20;
  localparam logic [5:0] SEL_CLR = 6'h21;

  // debugger select decode
  logic dbg_is_data, dbg_is_pb, cmd_wr, err_clr, buf_wr;
  assign dbg_is_data = (dbg_addr[5:4] == 2'b00) && (int'(dbg_addr[3:0]) < N_DATA);
  assign dbg_is_pb   = (dbg_addr[5:4] == 2'b01) && (int'(dbg_addr[3:0]) < N_PROGBUF);
  assign cmd_wr      = dbg_wr && (dbg_addr == SEL_CMD);
  assign err_clr     = dbg_wr && (dbg_addr == SEL_CLR);
  assign buf_wr      = dbg_wr && !dbg_addr[5];

  // hart store decode
  logic            hart_wr_hit;
  logic [DI_W-1:0] hart_wr_idx;
  assign hart_wr_hit = hart_wr && in_window(int'(hart_wr_addr), DATA_OFF, N_DATA);
  assign hart_wr_idx = DI_W'(word_of(int'(hart_wr_addr), DATA_OFF));

  logic [31:0] dec_w0, dec_w1, abs_w0, abs_w1;
  logic        cmd_bad, start_evt, bad_evt, busy_hit_evt;
  abs_err_e    err_q;
  logic [31:0] data_q [N_DATA];
  logic [31:0] pb_q   [N_PROGBUF];

  abs_cmd_decode #(.DATA_OFF(DATA_OFF)) u_dec (
    .cmd_word    (dbg_wdata),
    .word0       (dec_w0),
    .word1       (dec_w1),
    .unsupported (cmd_bad)
  );

  abs_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr       (cmd_wr),
    .cmd_bad      (cmd_bad),
    .dec_w0       (dec_w0),
    .dec_w1       (dec_w1),
    .err_clr      (err_clr),
    .buf_wr       (buf_wr),
    .hart_done    (hart_done),
    .busy         (busy),
    .go           (go),
    .err          (err_q),
    .abs_w0       (abs_w0),
    .abs_w1       (abs_w1),
    .start_evt    (start_evt),
    .bad_evt      (bad_evt),
    .busy_hit_evt (busy_hit_evt)
  );

  abs_store #(.N_DATA(N_DATA), .N_PROGBUF(N_PROGBUF), .IDX_W(IDX_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .allow       (!busy),
    .dbg_data_we (dbg_wr && dbg_is_data),
    .dbg_pb_we   (dbg_wr && dbg_is_pb),
    .dbg_idx     (dbg_addr[3:0]),
    .dbg_wdata   (dbg_wdata),
    .hart_we     (hart_wr_hit),
    .hart_idx    (hart_wr_idx),
    .hart_wdata  (hart_wr_data),
    .data_q      (data_q),
    .pb_q        (pb_q)
  );

  abs_fetch #(
    .N_DATA(N_DATA), .N_PROGBUF(N_PROGBUF), .N_ABS(N_ABS), .ADDR_W(ADDR_W),
    .DATA_OFF(DATA_OFF), .WHERETO_OFF(WHERETO_OFF)
  ) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (hart_rd_addr),
    .abs_w0  (abs_w0),
    .abs_w1  (abs_w1),
    .data_q  (data_q),
    .pb_q    (pb_q),
    .rd_data (hart_rd_data)
  );

  always_comb begin
    if (dbg_is_data)
      dbg_rdata = data_q[dbg_addr[DI_W-1:0]];
    else if (dbg_is_pb)
      dbg_rdata = pb_q[dbg_addr[PI_W-1:0]];
    else
      dbg_rdata = '0;
  end

  assign err = err_q;

endmodule

// File: rtl/abs_cmd_gen_chk.sv
module abs_cmd_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        go,
  input logic        busy,
  input logic        hart_done,
  input logic [1:0]  err,
  input logic        start_evt,
  input logic        bad_evt,
  input logic        busy_hit_evt,
  input logic        err_clr,
  input logic [31:0] abs_w0,
  input logic [31:0] abs_w1
);

  // R7: go lasts one cycle
  p_go_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);

  // R7: go only while busy
  p_go_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> busy);

  // R7: completion drops busy
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && hart_done |=> !busy);

  // R7: an accepted command raises go and busy
  p_start_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> go && busy);

  // R8: generated words hold while a command runs
  p_words_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(abs_w0) && $stable(abs_w1));

  // R8: access during a command flags a busy error
  p_busy_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_hit_evt |=> err == 2'd1);

  // R9: unsupported command never starts
  p_unsup_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> err == 2'd2 && !busy && !go);

  // R10: error persists until cleared
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err != 2'd0) && !err_clr |=> err == $past(err));

  // R10: clear strobe empties the error
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> err == 2'd0);

endmodule

bind abs_cmd_gen abs_cmd_gen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .go           (go),
  .busy         (busy),
  .hart_done    (hart_done),
  .err          (err),
  .start_evt    (start_evt),
  .bad_evt      (bad_evt),
  .busy_hit_evt (busy_hit_evt),
  .err_clr      (err_clr),
  .abs_w0       (abs_w0),
  .abs_w1       (abs_w1)
);

// File: tb/abs_cmd_gen_tb.sv
`timescale 1ns/1ps
module abs_cmd_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_wr = 1'b0;
  logic [5:0]  dbg_addr = '0;
  logic [31:0] dbg_wdata = '0;
  logic [31:0] dbg_rdata;
  logic [11:0] hart_rd_addr = '0;
  logic [31:0] hart_rd_data;
  logic        hart_wr = 1'b0;
  logic [11:0] hart_wr_addr = '0;
  logic [31:0] hart_wr_data = '0;
  logic        hart_done = 1'b0;
  logic        busy, go;
  logic [1:0]  err;

  int n_chk = 0;
  int n_err = 0;
  bit cmp_en = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  abs_cmd_gen u_dut (.*);

  localparam logic [31:0] NOP = 32'h0000_0013;
  localparam logic [31:0] EBK = 32'h0010_0073;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_data [4];
  logic [31:0] m_pb   [16];
  logic        m_busy, m_go;
  logic [1:0]  m_err;
  logic [31:0] m_w0, m_w1, m_hrd;

  function automatic logic [31:0] m_fetch(input logic [11:0] a);
    int w;
    w = int'(a) / 4;
    if (w == 192) return 32'h0380_006F;
    if (w == 206) return m_w0;
    if (w == 207) return m_w1;
    if (w >= 208 && w < 224) return m_pb[w - 208];
    if (w >= 224 && w < 228) return m_data[w - 224];
    return 32'h0;
  endfunction

  function automatic logic cmd_is_bad(input logic [31:0] c);
    return (c[31:24] != 8'd0) || (c[17] && !(c[22:20] == 3'd2 || c[22:20] == 3'd3));
  endfunction

  function automatic logic [31:0] cmd_first(input logic [31:0] c);
    if (!c[17]) return NOP;
    case ({c[16], c[20]})
      2'b11:   return 32'h3800_3403;
      2'b10:   return 32'h3800_2403;
      2'b01:   return 32'h3880_3023;
      default: return 32'h3880_2023;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_data[i]) m_data[i] = '0;
      foreach (m_pb[i])   m_pb[i]   = '0;
      m_busy = 0; m_go = 0; m_err = 0; m_hrd = 0;
      m_w0 = NOP; m_w1 = EBK;
    end else begin
      logic ob;
      ob    = m_busy;
      m_hrd = m_fetch(hart_rd_addr);
      m_go  = 0;
      if (hart_wr && hart_wr_addr >= 12'h380 && hart_wr_addr < 12'h390)
        m_data[(hart_wr_addr - 12'h380) >> 2] = hart_wr_data;
      if (hart_done && ob) m_busy = 0;
      if (dbg_wr) begin
        if (dbg_addr == 6'h21) m_err = 0;
        else if (dbg_addr == 6'h20) begin
          if (m_err != 0) ;
          else if (ob) m_err = 1;
          else if (cmd_is_bad(dbg_wdata)) m_err = 2;
          else begin
            m_busy = 1; m_go = 1;
            m_w0 = cmd_first(dbg_wdata);
            m_w1 = dbg_wdata[18] ? NOP : EBK;
          end
        end else if (!dbg_addr[5]) begin
          if (ob) begin
            if (m_err == 0) m_err = 1;
          end else if (dbg_addr[4]) m_pb[dbg_addr[3:0]] = dbg_wdata;
          else if (dbg_addr[3:0] < 4) m_data[dbg_addr[1:0]] = dbg_wdata;
        end
      end
    end
  end

  function automatic logic [31:0] m_dbg_rd(input logic [5:0] a);
    if (a[5:4] == 2'b00 && a[3:0] < 4) return m_data[a[1:0]];
    if (a[5:4] == 2'b01) return m_pb[a[3:0]];
    return 32'h0;
  endfunction

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R7 model busy", {31'd0, busy}, {31'd0, m_busy});
      chk("R7 model go",   {31'd0, go},   {31'd0, m_go});
      chk("R8 model err",  {30'd0, err},  {30'd0, m_err});
      chk("R2 model fetch", hart_rd_data, m_hrd);
      chk("R11 model dbg_rdata", dbg_rdata, m_dbg_rd(dbg_addr));
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic dbg_write(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    dbg_wr = 1; dbg_addr = a; dbg_wdata = d;
    @(posedge clk); #2;
    dbg_wr = 0;
  endtask

  task automatic dbg_read(input logic [5:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    dbg_addr = a;
    @(negedge clk);
    d = dbg_rdata;
  endtask

  task automatic hart_read(input logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    hart_rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = hart_rd_data;
  endtask

  task automatic hart_store(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    hart_wr = 1; hart_wr_addr = a; hart_wr_data = d;
    @(posedge clk); #2;
    hart_wr = 0;
  endtask

  task automatic finish_cmd();
    @(posedge clk); #2;
    hart_done = 1;
    @(posedge clk); #2;
    hart_done = 0;
    @(negedge clk);
    chk("R7 busy after done", {31'd0, busy}, 32'd0);
  endtask

  task automatic start_and_check(input string tag, input logic [31:0] cmd,
                                 input logic [31:0] e0, input logic [31:0] e1);
    logic [31:0] d;
    dbg_write(6'h20, cmd);
    @(negedge clk);
    chk({tag, " go"},   {31'd0, go},   32'd1);
    chk({tag, " busy"}, {31'd0, busy}, 32'd1);
    hart_read(12'h338, d);
    chk({tag, " word0"}, d, e0);
    hart_read(12'h33C, d);
    chk({tag, " word1"}, d, e1);
    finish_cmd();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    cmp_en = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 go",   {31'd0, go},   32'd0);
    chk("R1 err",  {30'd0, err},  32'd0);
    hart_read(12'h338, d); chk("R1 word0 nop", d, NOP);
    hart_read(12'h33C, d); chk("R1 word1 ebreak", d, EBK);
    hart_read(12'h380, d); chk("R1 data0 zero", d, 32'd0);

    // R2 jump word
    hart_read(12'h300, d); chk("R2 jump word", d, 32'h0380_006F);

    // fill buffer and data
    for (int i = 0; i < 16; i++) dbg_write(6'h10 + 6'(i), 32'hA000_0000 + i);
    dbg_write(6'h00, 32'h1234_5678);
    dbg_write(6'h01, 32'h9ABC_DEF0);

    // R11 / R6 layout
    hart_read(12'h340, d); chk("R11 pb0 fetch", d, 32'hA000_0000);
    hart_read(12'h37C, d); chk("R11 pb15 fetch", d, 32'hA000_000F);
    hart_read(12'h380, d); chk("R6 no implicit ebreak after buffer", d, 32'h1234_5678);
    dbg_read(6'h1A, d);    chk("R11 dbg pb10", d, 32'hA000_000A);

    // R12 unmapped
    hart_read(12'h200, d); chk("R12 unmapped low", d, 32'd0);
    hart_read(12'h390, d); chk("R12 past data", d, 32'd0);

    // R3 64-bit write with postexec
    dbg_write(6'h20, 32'h0037_1008);
    @(negedge clk);
    chk("R7 go on start", {31'd0, go}, 32'd1);
    chk("R7 busy on start", {31'd0, busy}, 32'd1);
    @(negedge clk);
    chk("R7 go one cycle", {31'd0, go}, 32'd0);
    hart_read(12'h338, d); chk("R3 ld s0", d, 32'h3800_3403);
    hart_read(12'h33C, d); chk("R6 postexec nop", d, NOP);

    // R8 busy error, writes ignored
    dbg_write(6'h20, 32'h0022_0000);
    @(negedge clk);
    chk("R8 busy err", {30'd0, err}, 32'd1);
    hart_read(12'h338, d); chk("R8 word0 kept", d, 32'h3800_3403);
    dbg_write(6'h21, 32'd0);
    dbg_write(6'h00, 32'hDEAD_BEEF);
    dbg_read(6'h00, d); chk("R8 data write ignored", d, 32'h1234_5678);
    chk("R8 err from data write", {30'd0, err}, 32'd1);
    dbg_write(6'h21, 32'd0);
    @(negedge clk);
    chk("R10 clear", {30'd0, err}, 32'd0);
    finish_cmd();

    // R11 hart store
    hart_store(12'h384, 32'hCAFE_F00D);
    dbg_read(6'h01, d); chk("R11 hart store data1", d, 32'hCAFE_F00D);

    // R4 / R5 / R6 / R3 variants
    start_and_check("R4 sw read32",   32'h0022_0000, 32'h3880_2023, EBK);
    start_and_check("R4 sd read64",   32'h0032_0000, 32'h3880_3023, EBK);
    start_and_check("R5 no transfer", 32'h0004_0000, NOP, NOP);
    start_and_check("R3 lw write32",  32'h0027_0000, 32'h3800_2403, NOP);

    // R9 unsupported size
    dbg_write(6'h20, 32'h0012_0000);
    @(negedge clk);
    chk("R9 size err", {30'd0, err}, 32'd2);
    chk("R9 no busy", {31'd0, busy}, 32'd0);
    chk("R9 no go", {31'd0, go}, 32'd0);
    hart_read(12'h338, d); chk("R9 word0 kept", d, 32'h3800_2403);

    // R10 sticky
    dbg_write(6'h20, 32'h0037_0000);
    @(negedge clk);
    chk("R10 cmd ignored busy", {31'd0, busy}, 32'd0);
    chk("R10 err sticky", {30'd0, err}, 32'd2);
    dbg_write(6'h21, 32'd0);

    // R9 unknown kind
    dbg_write(6'h20, 32'h0100_0000);
    @(negedge clk);
    chk("R9 kind err", {30'd0, err}, 32'd2);
    chk("R9 kind no busy", {31'd0, busy}, 32'd0);
    dbg_write(6'h21, 32'd0);

    repeat (3) @(posedge clk);
    @(negedge clk);
    summary();
  end

endmodule